// File: doc/BRIEF.md
# Semi-Decoupled Four-Phase Relay Stage

This block is a clocked stage between two four-phase return-to-zero channels. On the upstream side it takes a request, gives back an acknowledge and receives a 2-bit value. On the downstream side it raises a request, receives an acknowledge and presents a 4-bit word built from the value it captured. The two handshake inputs are first registered into the stage clock domain. So each handshake edge that comes in takes one clock to be sampled and one more clock before the stage answers it.

Flow control is semi-decoupled. When a request is seen and no earlier downstream acknowledge is still pending, the stage captures the input value. On the same clock edge it raises both the upstream acknowledge and the downstream request. The stage then withdraws its downstream request once the downstream acknowledge has been sampled. It keeps the upstream acknowledge high until that has happened, and until the upstream request has been sampled low. A new value is taken only after both channels are back at zero. The output word holds two copies of the captured value, so a receiver can check one copy against the other. In the bench, a source that steps through a 2-bit Gray code drives the stage.

Top module: `hs_relay_stage`

## Requirements
- R1: While reset is active and on the first clock after it, `in_ack`, `out_req` and `out_word` are all 0.
- R2: In the idle phase, when `in_req` has been high at one rising edge and `out_ack` was low at that edge, the next rising edge does two things. It captures `in_val`, and it raises the acknowledge and the request. Both outputs are therefore visible two edges after `in_req` is driven high.
- R3: `out_word[1:0]` and `out_word[3:2]` each equal the 2-bit value that was captured.
- R4: `in_ack` and `out_req` rise on the same clock edge.
- R5: `out_req` falls exactly two edges after `out_ack` is driven high, and never before `out_ack` has been sampled high.
- R6: `in_ack` stays high until `out_req` has fallen and `in_req` has been sampled low. It then falls on the next edge at which both conditions hold. It never falls while `out_req` is high.
- R7: `out_word` does not change from the rise of `out_req` until the stage has returned to idle, which is after `out_ack` has been sampled low.
- R8: No new value is accepted, and `in_ack` does not rise again, until `in_ack` is low and `out_ack` has been sampled low.
- R9: Changes on `in_val` outside the capture edge have no effect on `out_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_req | input | 1 | Upstream four-phase request |
| in_val | input | 2 | Upstream data, valid while `in_req` is high |
| in_ack | output | 1 | Upstream acknowledge |
| out_req | output | 1 | Downstream four-phase request |
| out_ack | input | 1 | Downstream acknowledge |
| out_word | output | 4 | Downstream data: two copies of the captured value |

## Verification
The assertions assume that both neighbours follow the four-phase rules. The upstream side drops its request only after it has seen the acknowledge, and it holds `in_val` from the rise of its request until the acknowledge arrives. The downstream side raises its acknowledge only while the request is high, and drops it only after the request has fallen. The bench source and sink are written as such neighbours, reacting only to port values at falling edges. They add varying wait times, including a slow sink that holds its acknowledge while the source already offers the next Gray value. The source also scrambles `in_val` once its request has been acknowledged, to show that the data is held.

// File: rtl/hs_relay_pkg.sv
// Shared types for the semi-decoupled relay stage.
package hs_relay_pkg;
    // Control phases of the relay controller.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // both channels at zero, ready to accept
        PH_OFFER  = 2'd1,  // input acknowledged, output requested
        PH_RETIRE = 2'd2   // output request withdrawn, closing both channels
    } relay_phase_e;
endpackage

// File: rtl/hs_relay_sync.sv
// Registers handshake inputs into the local clock domain.
// Assumes each input is a level that changes at most once per handshake phase.
module hs_relay_sync #(
    parameter int W      = 2,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First sampling flop takes the port level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // Further flops extend the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_relay_widen.sv
// Builds the output word from COPIES copies of the captured value.
// Purely combinational; assumes the value is held stable by its producer.
module hs_relay_widen #(
    parameter int IN_W   = 2,
    parameter int COPIES = 2,
    localparam int OUT_W = IN_W * COPIES
) (
    input  logic [IN_W-1:0]  val,
    output logic [OUT_W-1:0] word
);
    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        // Each slice carries one copy of the value.
        assign word[c*IN_W +: IN_W] = val;
    end
endmodule

// File: rtl/hs_relay_ctl.sv
// Semi-decoupled handshake controller. It captures the input value and raises
// the input acknowledge together with the output request. It completes the
// input return-to-zero only after the output acknowledge has been sampled.
// Assumes req_s and ack_s are already registered in this clock domain.
module hs_relay_ctl
    import hs_relay_pkg::*;
#(
    parameter int IN_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_s,
    input  logic            ack_s,
    input  logic [IN_W-1:0] val,
    output logic            in_ack,
    output logic            out_req,
    output logic [IN_W-1:0] held
);
    relay_phase_e phase_q;

    // Phase sequencing, handshake outputs and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            in_ack  <= 1'b0;
            out_req <= 1'b0;
            held    <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (req_s && !ack_s) begin
                        held    <= val;
                        in_ack  <= 1'b1;
                        out_req <= 1'b1;
                        phase_q <= PH_OFFER;
                    end
                end
                PH_OFFER: begin
                    if (ack_s) begin
                        out_req <= 1'b0;
                        phase_q <= PH_RETIRE;
                    end
                end
                PH_RETIRE: begin
                    if (in_ack && !req_s) begin
                        in_ack <= 1'b0;
                    end else if (!in_ack && !ack_s) begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> $rose(out_req)); // R4

    AST_DROP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_req) |-> $past(ack_s)); // R5

    AST_ACK_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack) |-> !out_req); // R6

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && $past(phase_q != PH_IDLE)) |-> $stable(held)); // R7

    AST_NO_EARLY_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ack) |-> ($past(!ack_s) && $past(phase_q == PH_IDLE))); // R8
endmodule

// File: rtl/hs_relay_stage.sv
// Top of the semi-decoupled four-phase relay stage.
// Assumes four-phase return-to-zero neighbours that hold in_val while in_req is
// high and unacknowledged.
module hs_relay_stage #(
    parameter int IN_W        = 2,
    parameter int COPIES      = 2,
    parameter int SYNC_STAGES = 1,
    localparam int OUT_W      = IN_W * COPIES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [IN_W-1:0]  in_val,
    output logic             in_ack,
    output logic             out_req,
    input  logic             out_ack,
    output logic [OUT_W-1:0] out_word
);
    logic [1:0]      hs_s;
    logic [IN_W-1:0] held;

    hs_relay_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({out_ack, in_req}),
        .q     (hs_s)
    );

    hs_relay_ctl #(.IN_W(IN_W)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_s   (hs_s[0]),
        .ack_s   (hs_s[1]),
        .val     (in_val),
        .in_ack  (in_ack),
        .out_req (out_req),
        .held    (held)
    );

    hs_relay_widen #(.IN_W(IN_W), .COPIES(COPIES)) u_widen (
        .val  (held),
        .word (out_word)
    );
endmodule

// File: tb/tb_hs_relay_stage.sv
module tb_hs_relay_stage;
    localparam int NITEMS = 40;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       in_req = 0;
    logic [1:0] in_val = 0;
    logic       in_ack;
    logic       out_req;
    logic       out_ack = 0;
    logic [3:0] out_word;

    int n_vec = 0;
    int n_bad = 0;
    int got   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    hs_relay_stage dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_val(in_val),
        .in_ack(in_ack), .out_req(out_req), .out_ack(out_ack), .out_word(out_word)
    );

    // Behavioural reference: sampled inputs, step counter, expected outputs.
    bit   m_req_s, m_ack_s, e_in_ack, e_out_req;
    logic [3:0] e_word;
    int   m_step;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req_s = 0; m_ack_s = 0; e_in_ack = 0; e_out_req = 0; e_word = 0; m_step = 0;
        end else begin
            if (m_step == 0) begin
                if (m_req_s && !m_ack_s) begin
                    e_word = {in_val, in_val};
                    e_in_ack = 1; e_out_req = 1; m_step = 1;
                end
            end else if (m_step == 1) begin
                if (m_ack_s) begin e_out_req = 0; m_step = 2; end
            end else begin
                if (e_in_ack && !m_req_s) e_in_ack = 0;
                else if (!e_in_ack && !m_ack_s) m_step = 0;
            end
            m_req_s = in_req;
            m_ack_s = out_ack;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle compare against the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ack == e_in_ack, "R6 in_ack", in_ack, e_in_ack);
            check(out_req == e_out_req, "R5 out_req", out_req, e_out_req);
            check(out_word == e_word, "R7 out_word", out_word, e_word);
        end
    end

    // Upstream source: 2-bit Gray code, scrambles data after acknowledge (R9).
    initial begin
        @(posedge rst_n);
        for (int i = 0; i < NITEMS; i++) begin
            @(negedge clk);
            in_val = 2'(i ^ (i >> 1));
            repeat (i % 3) @(negedge clk);
            in_req = 1;
            while (!in_ack) @(negedge clk);
            check(out_req == 1, "R4 out_req with in_ack", out_req, 1);
            in_val = ~in_val;
            repeat ((i * 3) % 4) @(negedge clk);
            in_req = 0;
            while (in_ack) @(negedge clk);
        end
    end

    // Downstream sink: checks both copies and Gray order, varied delays.
    initial begin
        @(posedge rst_n);
        for (int k = 0; k < NITEMS; k++) begin
            int lat;
            logic [1:0] g;
            lat = (k >= 20 && k < 28) ? 8 : (k * 7) % 5;
            g = 2'(k ^ (k >> 1));
            @(negedge clk);
            while (!out_req) @(negedge clk);
            repeat (lat) @(negedge clk);
            check(in_ack == 1, "R6 in_ack held before out_ack", in_ack, 1);
            check(out_word[1:0] == out_word[3:2], "R3 copies", out_word, {out_word[1:0], out_word[1:0]});
            check(out_word == {g, g}, "R2 R9 captured Gray value", out_word, {g, g});
            out_ack = 1;
            @(negedge clk);
            check(out_req == 1, "R5 no early drop", out_req, 1);
            @(negedge clk);
            check(out_req == 0, "R5 drop after two edges", out_req, 0);
            repeat (lat) @(negedge clk);
            if (lat == 8) check(out_req == 0 && (in_ack == 0 || in_req == 1),
                                "R8 no accept while out_ack high", {out_req, in_ack}, 0);
            out_ack = 0;
            got++;
        end
        repeat (6) @(negedge clk);
        done = 1;
    end

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(in_ack == 0 && out_req == 0 && out_word == 0, "R1 reset",
              {in_ack, out_req, out_word}, 0);
        rst_n = 1;
        @(negedge clk);
        check(in_ack == 0 && out_req == 0 && out_word == 0, "R1 after reset",
              {in_ack, out_req, out_word}, 0);
        fork
            wait (done);
            begin
                repeat (20000) @(negedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", got, NITEMS);
            end
        join_any
        check(got == NITEMS, "R2 item count", got, NITEMS);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule